// File: doc/BRIEF.md
# Stop-and-Wait Segment Transmitter

This block moves application payload across an already open TCP connection, one segment at a time. A strobe from the connection manager wakes it. It first checks whether the application has anything left to send. If there is nothing, it returns control with a one-cycle resume pulse. If there is payload, it collects the bytes into a local segment store until the application marks the last byte or the store is full. It then waits for the IP layer to signal readiness and streams an 8-byte header followed by the payload, one byte per cycle.

After the final byte, the block pulses a start signal to the separate acknowledgment receiver and waits for that receiver's ACK indication. When an ACK arrives, the sequence number advances by the payload length and the block checks for more data. When the timeout window closes without an ACK, it raises a repeat request and sends the stored segment again at the next readiness from the IP layer. A retransmission never reads from the application.

The header carries four fields, most significant byte first. Bytes 0–1 hold the source port, bytes 2–3 the destination port and bytes 4–7 the 32-bit sequence number. Checksums, windowing and more than one outstanding segment are not part of this block.

Top module: `tcp_tx_engine`

## Requirements
- R1: After reset the block is idle: `app_ready_o`, `send_valid_o`, `resume_o`, `repeat_o` and `rx_start_o` are all 0. They stay 0 until `init_i` is sampled high.
- R2: In the check cycle that follows `init_i` or an accepted ACK, `resume_o` is 1 exactly when `no_data_i` is 1. After a resume pulse the block is idle again, and `app_ready_o` stays 0.
- R3: When `no_data_i` is 0, the block enters a load phase with `app_ready_o` high. It takes one byte in each cycle that has `app_valid_i` high, and cycles without a valid byte are simply waited through. The load ends on a byte that has `app_last_i` high, or on byte number MAX_SEG.
- R4: After loading, no byte is sent until `send_ready_i` is sampled high. The first byte appears in the cycle after that sample.
- R5: A segment is sent as an uninterrupted run of 8+N cycles with `send_valid_o` high, where N is the payload length. Bytes 0–1 are the source port, bytes 2–3 the destination port and bytes 4–7 the sequence number, each field MSB first. The N payload bytes follow in the order they were loaded. `send_last_o` is high only on the final byte.
- R6: `rx_start_o` pulses for exactly one cycle, in the cycle that follows the final byte.
- R7: If no ACK arrives, `repeat_o` is high in the TIMEOUT-th cycle after the final byte. The block then waits for `send_ready_i` again.
- R8: A retransmission repeats the stored segment byte for byte, with the same sequence number. `app_ready_o` stays 0 while it happens.
- R9: An `ack_i` pulse inside the wait window advances the sequence number by N and leads to the check cycle. If the ACK comes in the same cycle as the timeout, the ACK wins and `repeat_o` stays 0.
- R10: `ack_i` outside the wait window has no effect. The next header shows an unchanged sequence number.
- R11: A segment never holds more than MAX_SEG payload bytes. When `app_last_i` is missing, the load stops after MAX_SEG bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Start strobe from the connection manager |
| no_data_i | input | 1 | Application has no more payload |
| app_valid_i | input | 1 | Application payload byte present |
| app_data_i | input | 8 | Application payload byte |
| app_last_i | input | 1 | Marks the last payload byte of a segment |
| app_ready_o | output | 1 | Block is accepting payload bytes |
| send_ready_i | input | 1 | IP layer can take a segment |
| send_valid_o | output | 1 | Segment byte on `send_data_o` |
| send_data_o | output | 8 | Segment byte to the IP layer |
| send_last_o | output | 1 | Final byte of the segment |
| rx_start_o | output | 1 | Hands control to the ACK receiver |
| ack_i | input | 1 | ACK seen by the receiver |
| repeat_o | output | 1 | Timeout expired; segment will be resent |
| resume_o | output | 1 | Returns control to the connection manager |

## Verification
The assertions assume that the IP layer and the ACK receiver react only to the block's own handshakes. In particular, they assume `send_ready_i` is what starts a burst, and that a segment is never cut short from outside. The stimulus drives `send_ready_i` only while a loaded segment is waiting, and holds it low for a random number of cycles first. It keeps `no_data_i` stable across each check cycle. It also sends stray `ack_i` pulses only while the segment waits for the IP layer, so the ACK window itself is reached only by bench-timed pulses or by letting the timeout expire.

// File: rtl/tcp_tx_engine.sv
module tcp_tx_engine #(
  parameter int          MAX_SEG  = 16,
  parameter int          TIMEOUT  = 40,
  parameter logic [15:0] SRC_PORT = 16'h0050,
  parameter logic [15:0] DST_PORT = 16'hC001,
  parameter logic [31:0] SEQ_INIT = 32'h0000_0100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_i,
  input  logic       no_data_i,
  input  logic       app_valid_i,
  input  logic [7:0] app_data_i,
  input  logic       app_last_i,
  output logic       app_ready_o,
  input  logic       send_ready_i,
  output logic       send_valid_o,
  output logic [7:0] send_data_o,
  output logic       send_last_o,
  output logic       rx_start_o,
  input  logic       ack_i,
  output logic       repeat_o,
  output logic       resume_o
);
  localparam int HDR = 8;
  localparam int AW  = (MAX_SEG > 1) ? $clog2(MAX_SEG) : 1;
  localparam int LW  = $clog2(MAX_SEG + 1);
  localparam int IW  = $clog2(MAX_SEG + HDR + 1);
  localparam int TW  = $clog2(TIMEOUT + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_LOAD, S_WAIT_IP, S_SEND, S_WAIT_ACK} st_t;

  st_t           st;
  logic [7:0]    seg_mem [MAX_SEG];
  logic [LW-1:0] len;
  logic [IW-1:0] idx;
  logic [TW-1:0] tmr;
  logic [31:0]   seq;
  logic          rx_start_q;
  logic [IW-1:0] pidx;

  wire take      = (st == S_LOAD) && app_valid_i;
  wire load_done = take && (app_last_i || len == LW'(MAX_SEG - 1));
  wire final_b   = (st == S_SEND) && (idx == IW'(HDR - 1) + IW'(len));
  wire ack_hit   = (st == S_WAIT_ACK) && ack_i;
  wire expire    = (st == S_WAIT_ACK) && !ack_i && (tmr == TW'(TIMEOUT - 1));

  assign pidx         = idx - IW'(HDR);
  assign app_ready_o  = (st == S_LOAD);
  assign send_valid_o = (st == S_SEND);
  assign send_last_o  = final_b;
  assign rx_start_o   = rx_start_q;
  assign repeat_o     = expire;
  assign resume_o     = (st == S_START) && no_data_i;

  always_comb begin
    case (idx)
      IW'(0):  send_data_o = SRC_PORT[15:8];
      IW'(1):  send_data_o = SRC_PORT[7:0];
      IW'(2):  send_data_o = DST_PORT[15:8];
      IW'(3):  send_data_o = DST_PORT[7:0];
      IW'(4):  send_data_o = seq[31:24];
      IW'(5):  send_data_o = seq[23:16];
      IW'(6):  send_data_o = seq[15:8];
      IW'(7):  send_data_o = seq[7:0];
      default: send_data_o = seg_mem[pidx[AW-1:0]];
    endcase
  end

  always_ff @(posedge clk) begin
    if (take) seg_mem[len[AW-1:0]] <= app_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      len        <= '0;
      idx        <= '0;
      tmr        <= '0;
      seq        <= SEQ_INIT;
      rx_start_q <= 1'b0;
    end else begin
      rx_start_q <= final_b;
      case (st)
        S_IDLE:  if (init_i) st <= S_START;
        S_START: begin
          if (no_data_i) st <= S_IDLE;
          else begin
            st  <= S_LOAD;
            len <= '0;
          end
        end
        S_LOAD: if (take) begin
          len <= len + 1'b1;
          if (load_done) st <= S_WAIT_IP;
        end
        S_WAIT_IP: if (send_ready_i) begin
          st  <= S_SEND;
          idx <= '0;
        end
        S_SEND: begin
          if (final_b) begin
            st  <= S_WAIT_ACK;
            tmr <= '0;
          end else idx <= idx + 1'b1;
        end
        S_WAIT_ACK: begin
          if (ack_hit) begin
            seq <= seq + 32'(len);
            st  <= S_START;
          end else if (expire) st <= S_WAIT_IP;
          else tmr <= tmr + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module tcp_tx_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       init_i,
  input logic       no_data_i,
  input logic       app_valid_i,
  input logic [7:0] app_data_i,
  input logic       app_last_i,
  input logic       app_ready_o,
  input logic       send_ready_i,
  input logic       send_valid_o,
  input logic [7:0] send_data_o,
  input logic       send_last_o,
  input logic       rx_start_o,
  input logic       ack_i,
  input logic       repeat_o,
  input logic       resume_o
);
  // R4
  burst_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(send_valid_o) |-> $past(send_ready_i));
  // R5
  burst_contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (send_valid_o && !send_last_o) |=> send_valid_o);
  // R6
  handoff_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_last_o |=> (rx_start_o && !send_valid_o));
  // R7
  repeat_waits_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    repeat_o |=> (!send_valid_o && !app_ready_o));
  // R2
  resume_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |=> (!app_ready_o && !send_valid_o && !resume_o));
  // R3
  load_excludes_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({app_ready_o, send_valid_o, resume_o, repeat_o}));
  // R5
  last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_last_o |-> send_valid_o);
endmodule

bind tcp_tx_engine tcp_tx_engine_chk u_chk (.*);

// File: tb/tcp_tx_engine_tb.sv
`timescale 1ns/1ps
module tcp_tx_engine_tb;
  localparam int          MAX_SEG  = 16;
  localparam int          TIMEOUT  = 20;
  localparam logic [15:0] SRC_PORT = 16'h1F90;
  localparam logic [15:0] DST_PORT = 16'hC350;
  localparam logic [31:0] SEQ_INIT = 32'hFFFF_FFF8;

  logic clk = 0, rst_n = 0;
  logic init_i = 0, no_data_i = 0, app_valid_i = 0, app_last_i = 0;
  logic [7:0] app_data_i = 0;
  logic send_ready_i = 0, ack_i = 0;
  logic app_ready_o, send_valid_o, send_last_o, rx_start_o, repeat_o, resume_o;
  logic [7:0] send_data_o;

  int checks = 0, fails = 0;
  logic [31:0] seq_m;
  logic [7:0] pay [MAX_SEG];
  int plen;

  always #4 clk = ~clk;

  tcp_tx_engine #(.MAX_SEG(MAX_SEG), .TIMEOUT(TIMEOUT), .SRC_PORT(SRC_PORT),
    .DST_PORT(DST_PORT), .SEQ_INIT(SEQ_INIT)) u_dut (
    .clk, .rst_n, .init_i, .no_data_i, .app_valid_i, .app_data_i, .app_last_i,
    .app_ready_o, .send_ready_i, .send_valid_o, .send_data_o, .send_last_o,
    .rx_start_o, .ack_i, .repeat_o, .resume_o);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int k);
    case (k)
      0: return SRC_PORT[15:8];
      1: return SRC_PORT[7:0];
      2: return DST_PORT[15:8];
      3: return DST_PORT[7:0];
      4: return seq_m[31:24];
      5: return seq_m[23:16];
      6: return seq_m[15:8];
      7: return seq_m[7:0];
      default: return pay[k-8];
    endcase
  endfunction

  // Block is in its send-ready wait; stray acks are ignored there (R10).
  task automatic send_frame(input bit retx);
    int d = $urandom_range(0, 4);
    for (int i = 0; i < d; i++) begin
      ack_i = ($urandom_range(0, 1) == 1);
      #1;
      chk(send_valid_o == 0, "R4", send_valid_o, 0);
      chk(app_ready_o == 0, retx ? "R8" : "R4", app_ready_o, 0);
      @(negedge clk);
    end
    ack_i = 0;
    send_ready_i = 1;
    @(negedge clk);
    send_ready_i = 0;
    for (int k = 0; k < 8 + plen; k++) begin
      chk(send_valid_o == 1, "R5", send_valid_o, 1);
      chk(send_data_o == exp_byte(k), retx ? "R8" : (k < 8 ? "R10" : "R5"), send_data_o, exp_byte(k));
      chk(send_last_o == (k == 7 + plen), "R5", send_last_o, k == 7 + plen);
      chk(rx_start_o == 0, "R6", rx_start_o, 0);
      @(negedge clk);
    end
    chk(rx_start_o == 1, "R6", rx_start_o, 1);
    chk(send_valid_o == 0, "R5", send_valid_o, 0);
  endtask

  // Starts at the negedge of the check cycle with no_data_i = 0.
  task automatic segment(input int n, input bit use_last, input int timeouts, input int ack_at);
    #1;
    chk(resume_o == 0, "R2", resume_o, 0);
    @(negedge clk);
    plen = n;
    for (int i = 0; i < n; i++) begin
      int g = $urandom_range(0, 2);
      for (int j = 0; j < g; j++) begin
        app_valid_i = 0;
        chk(app_ready_o == 1, "R3", app_ready_o, 1);
        @(negedge clk);
      end
      chk(app_ready_o == 1, "R3", app_ready_o, 1);
      pay[i] = 8'($urandom);
      app_valid_i = 1;
      app_data_i = pay[i];
      app_last_i = use_last && (i == n - 1);
      @(negedge clk);
    end
    app_valid_i = 0;
    app_last_i = 0;
    chk(app_ready_o == 0, use_last ? "R3" : "R11", app_ready_o, 0);
    send_frame(0);
    for (int t = 0; t < timeouts; t++) begin
      for (int c = 1; c < TIMEOUT; c++) begin
        chk(repeat_o == 0, "R7", repeat_o, 0);
        @(negedge clk);
      end
      chk(repeat_o == 1, "R7", repeat_o, 1);
      @(negedge clk);
      chk(repeat_o == 0, "R7", repeat_o, 0);
      send_frame(1);
    end
    for (int c = 1; c < ack_at; c++) @(negedge clk);
    ack_i = 1;
    #1;
    chk(repeat_o == 0, "R9", repeat_o, 0);
    @(negedge clk);
    ack_i = 0;
    seq_m = seq_m + 32'(n);
  endtask

  initial begin
    seq_m = SEQ_INIT;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk({app_ready_o, send_valid_o, resume_o, repeat_o, rx_start_o} == 0, "R1",
          {app_ready_o, send_valid_o, resume_o, repeat_o, rx_start_o}, 0);
      ack_i = (i == 1);
      send_ready_i = (i == 2);
      @(negedge clk);
    end
    ack_i = 0;
    send_ready_i = 0;
    chk(app_ready_o == 0 && send_valid_o == 0, "R1", {app_ready_o, send_valid_o}, 0);
    init_i = 1;
    @(negedge clk);
    init_i = 0;
    segment(5, 1, 0, 3);
    segment(7, 1, 1, TIMEOUT);
    segment(MAX_SEG, 0, 0, 2);
    segment(1, 1, 2, 1);
    for (int r = 0; r < 20; r++)
      segment($urandom_range(1, MAX_SEG), 1, $urandom_range(0, 1), $urandom_range(1, TIMEOUT));
    no_data_i = 1;
    #1;
    chk(resume_o == 1, "R2", resume_o, 1);
    @(negedge clk);
    chk(resume_o == 0, "R2", resume_o, 0);
    for (int i = 0; i < 3; i++) begin
      chk(app_ready_o == 0, "R2", app_ready_o, 0);
      @(negedge clk);
    end
    no_data_i = 0;
    init_i = 1;
    @(negedge clk);
    init_i = 0;
    segment(4, 1, 0, 5);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule